// File: doc/BRIEF.md
# Dual-Rate LFSR Pattern Source

This block feeds test stimulus to a circuit under test from two linear feedback shift registers running at different rates. A fast register steps on every clock and drives one group of inputs. A slow register steps only once every `2**RATIO_LOG2` clocks, so the inputs it drives toggle far less often and burn less switching power. Both registers use primitive feedback and start from non-zero seeds.

The slow register has a second job. With `sig_mode` high it steps on every clock as a multiple-input signature register, folding one response bit into each stage. The final signature can then be read from the upper field of `pattern`. The rate divider is a small counter that produces a one-cycle step enable. It does not derive a second clock, so all state lives in one clock domain.

Top module: `dual_rate_pattern_src`

## Requirements
- R1: While `rst_n` is low, `pattern` equals `{SLOW_SEED, FAST_SEED}` (defaults 8'hA5 and 8'h01).
- R2: The fast field `pattern[7:0]` steps on every clock after reset: next = `{q[6:0], ^(q & 8'hB8)}`.
- R3: The divider counts every clock in both modes, starting from 0 at reset. In pattern mode (`sig_mode`=0) the slow field `pattern[15:8]` holds on every clock except one where the divider is at `d-1` (d=4 by default). The first slow step is therefore on the 4th rising edge after reset release, and later steps come every 4th edge.
- R4: A slow step in pattern mode applies next = `{q[6:0], ^(q & 8'h8E)}`.
- R5: In signature mode (`sig_mode`=1) the slow field steps on every clock: next = `{q[6:0], ^(q & 8'h8E)} ^ resp`.
- R6: In pattern mode, `resp` has no effect on `pattern`.
- R7: `sig_mode` and `resp` have no effect on the fast field.
- R8: The fast field is never zero, and it returns to its seed after exactly 255 steps and not before.
- R9: Time spent in signature mode does not reset the divider phase. After a return to pattern mode, the next slow step falls where the free-running count of R3 places it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sig_mode | input | 1 | 0: slow register generates patterns at 1/d rate; 1: slow register compacts `resp` every clock |
| resp | input | SLOW_W | Response word folded into the slow register in signature mode |
| pattern | output | SLOW_W+FAST_W | `{slow state, fast state}`; the upper field is the signature in signature mode |

## Verification
Long pattern-mode runs with a zero response check both step rules and the 1-in-4 spacing of slow steps. Pattern-mode runs with busy response words show whether the response leaks into the slow field. Signature runs use both non-zero and zero responses, which separates the feedback path from the injection path. Short signature interludes that end at different divider phases show whether the divider keeps counting through the mode switches. A full 255-step fast run pins down the period and the non-zero property.

// File: rtl/dr_pkg.sv
`timescale 1ns/1ps
package dr_pkg;
    typedef enum logic {
        MODE_PATTERN   = 1'b0,
        MODE_SIGNATURE = 1'b1
    } src_mode_e;
endpackage

// File: rtl/dr_rate_div.sv
`timescale 1ns/1ps
module dr_rate_div #(
    parameter int RATIO_LOG2 = 2
) (
    input  logic clk,
    input  logic rst_n,
    output logic step_tick
);
    localparam int CNT_W = (RATIO_LOG2 > 0) ? RATIO_LOG2 : 1;

    generate
        if (RATIO_LOG2 == 0) begin : g_full_rate
            assign step_tick = 1'b1;
        end else begin : g_divided
            typedef struct packed {
                logic [CNT_W-1:0] cnt;
            } div_state_t;

            div_state_t div_d, div_q;

            always_comb begin
                div_d     = div_q;
                div_d.cnt = div_q.cnt + 1'b1;
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) div_q <= '0;
                else        div_q <= div_d;
            end

            assign step_tick = &div_q.cnt;
        end
    endgenerate
endmodule

// File: rtl/dr_lfsr_core.sv
`timescale 1ns/1ps
module dr_lfsr_core #(
    parameter int           W     = 8,
    parameter logic [W-1:0] TAPS  = 8'hB8,
    parameter logic [W-1:0] SEED  = 8'h01
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         adv,
    input  logic [W-1:0] inj,
    output logic [W-1:0] state
);
    typedef struct packed {
        logic [W-1:0] val;
    } shift_state_t;

    shift_state_t sh_d, sh_q;
    logic         fb;

    always_comb begin
        fb   = ^(sh_q.val & TAPS);
        sh_d = sh_q;
        if (adv) begin
            sh_d.val = {sh_q.val[W-2:0], fb} ^ inj;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q.val <= SEED;
        else        sh_q     <= sh_d;
    end

    assign state = sh_q.val;
endmodule

// File: rtl/dual_rate_pattern_src.sv
`timescale 1ns/1ps
module dual_rate_pattern_src #(
    parameter int                FAST_W     = 8,
    parameter int                SLOW_W     = 8,
    parameter logic [FAST_W-1:0] FAST_TAPS  = 8'hB8,
    parameter logic [SLOW_W-1:0] SLOW_TAPS  = 8'h8E,
    parameter logic [FAST_W-1:0] FAST_SEED  = 8'h01,
    parameter logic [SLOW_W-1:0] SLOW_SEED  = 8'hA5,
    parameter int                RATIO_LOG2 = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     sig_mode,
    input  logic [SLOW_W-1:0]        resp,
    output logic [SLOW_W+FAST_W-1:0] pattern
);
    import dr_pkg::*;

    localparam int OUT_W = SLOW_W + FAST_W;

    src_mode_e          mode;
    logic               step_tick;
    logic               slow_adv;
    logic [SLOW_W-1:0]  slow_inj;
    logic [FAST_W-1:0]  fast_state;
    logic [SLOW_W-1:0]  slow_state;

    assign mode = src_mode_e'(sig_mode);

    always_comb begin
        slow_adv = 1'b0;
        slow_inj = '0;
        case (mode)
            MODE_SIGNATURE: begin
                slow_adv = 1'b1;
                slow_inj = resp;
            end
            default: begin
                slow_adv = step_tick;
            end
        endcase
    end

    dr_rate_div #(
        .RATIO_LOG2 (RATIO_LOG2)
    ) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .step_tick (step_tick)
    );

    dr_lfsr_core #(
        .W    (FAST_W),
        .TAPS (FAST_TAPS),
        .SEED (FAST_SEED)
    ) u_fast (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (1'b1),
        .inj   ({FAST_W{1'b0}}),
        .state (fast_state)
    );

    dr_lfsr_core #(
        .W    (SLOW_W),
        .TAPS (SLOW_TAPS),
        .SEED (SLOW_SEED)
    ) u_slow (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (slow_adv),
        .inj   (slow_inj),
        .state (slow_state)
    );

    assign pattern = OUT_W'({slow_state, fast_state});
endmodule

// File: rtl/dr_src_checker.sv
`timescale 1ns/1ps
module dr_src_checker #(
    parameter int                FAST_W     = 8,
    parameter int                SLOW_W     = 8,
    parameter logic [FAST_W-1:0] FAST_TAPS  = 8'hB8,
    parameter logic [SLOW_W-1:0] SLOW_TAPS  = 8'h8E,
    parameter int                RATIO_LOG2 = 2
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     sig_mode,
    input logic [SLOW_W-1:0]        resp,
    input logic [SLOW_W+FAST_W-1:0] pattern,
    input logic                     step_tick
);
    localparam int GAP_W = RATIO_LOG2 + 1;
    localparam logic [GAP_W-1:0] LAST = GAP_W'((1 << RATIO_LOG2) - 1);

    logic [FAST_W-1:0] fast;
    logic [SLOW_W-1:0] slow;
    logic [GAP_W-1:0]  gap_q;

    assign fast = pattern[FAST_W-1:0];
    assign slow = pattern[FAST_W +: SLOW_W];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         gap_q <= '0;
        else if (step_tick) gap_q <= '0;
        else                gap_q <= gap_q + 1'b1;
    end

    AST_FAST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> fast == {$past(fast[FAST_W-2:0]), ^($past(fast) & FAST_TAPS)}); // R2

    AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        step_tick |-> gap_q == LAST); // R3

    AST_SLOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!sig_mode && !step_tick) |=> $stable(slow)); // R3

    AST_SLOW_PATTERN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!sig_mode && step_tick) |=>
            slow == {$past(slow[SLOW_W-2:0]), ^($past(slow) & SLOW_TAPS)}); // R4

    AST_SIG_COMPACT: assert property (@(posedge clk) disable iff (!rst_n)
        sig_mode |=>
            slow == ({$past(slow[SLOW_W-2:0]), ^($past(slow) & SLOW_TAPS)} ^ $past(resp))); // R5

    AST_FAST_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        fast != '0); // R8
endmodule

bind dual_rate_pattern_src dr_src_checker #(
    .FAST_W     (FAST_W),
    .SLOW_W     (SLOW_W),
    .FAST_TAPS  (FAST_TAPS),
    .SLOW_TAPS  (SLOW_TAPS),
    .RATIO_LOG2 (RATIO_LOG2)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sig_mode  (sig_mode),
    .resp      (resp),
    .pattern   (pattern),
    .step_tick (step_tick)
);

// File: tb/dual_rate_pattern_src_bench.sv
`timescale 1ns/1ps
module dual_rate_pattern_src_bench;
    localparam logic [7:0] F_TAPS = 8'hB8;
    localparam logic [7:0] S_TAPS = 8'h8E;
    localparam logic [7:0] F_SEED = 8'h01;
    localparam logic [7:0] S_SEED = 8'hA5;
    localparam int         DIV    = 4;

    typedef struct packed {
        logic       mode;
        logic [7:0] resp;
        logic [7:0] n;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 8'h00, 8'd9},
        '{1'b0, 8'hFF, 8'd6},
        '{1'b1, 8'h3C, 8'd5},
        '{1'b1, 8'h00, 8'd3},
        '{1'b0, 8'h5A, 8'd7},
        '{1'b1, 8'hC3, 8'd2},
        '{1'b0, 8'h00, 8'd8},
        '{1'b1, 8'h81, 8'd1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sig_mode = 1'b0;
    logic [7:0]  resp = 8'h00;
    logic [15:0] pattern;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    logic [7:0] m_fast, m_slow;
    int         m_cnt;

    always #2 clk = ~clk;

    dual_rate_pattern_src u_dual_rate_pattern_src (
        .clk      (clk),
        .rst_n    (rst_n),
        .sig_mode (sig_mode),
        .resp     (resp),
        .pattern  (pattern)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        sig_mode = 1'b0;
        resp = 8'h00;
        @(negedge clk);
        @(negedge clk);
        check("R1", pattern[15:8], S_SEED);
        check("R1", pattern[7:0], F_SEED);
        m_fast = F_SEED;
        m_slow = S_SEED;
        m_cnt  = 0;
        rst_n  = 1'b1;
    endtask

    task automatic run(input logic md, input logic [7:0] rs, input int n, input string force_tag);
        sig_mode = md;
        resp = rs;
        for (int i = 0; i < n; i++) begin
            string stag;
            string ftag;
            bit tick;
            @(posedge clk);
            tick   = (m_cnt == DIV - 1);
            m_cnt  = (m_cnt + 1) % DIV;
            m_fast = {m_fast[6:0], ^(m_fast & F_TAPS)};
            if (md)        m_slow = {m_slow[6:0], ^(m_slow & S_TAPS)} ^ rs;
            else if (tick) m_slow = {m_slow[6:0], ^(m_slow & S_TAPS)};
            if (force_tag != "")  stag = force_tag;
            else if (md)          stag = "R5";
            else if (rs != 8'h00) stag = "R6";
            else if (tick)        stag = "R4";
            else                  stag = "R3";
            ftag = md ? "R7" : "R2";
            @(negedge clk);
            check(stag, pattern[15:8], m_slow);
            check(ftag, pattern[7:0], m_fast);
        end
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        do_reset();
        for (int v = 0; v < NVEC; v++) begin
            run(VECS[v].mode, VECS[v].resp, int'(VECS[v].n), "");
        end

        // R9: signature interludes ending at different divider phases
        do_reset();
        run(1'b0, 8'h00, 2, "R9");
        run(1'b1, 8'h11, 3, "R9");
        run(1'b0, 8'h00, 6, "R9");
        run(1'b1, 8'h00, 1, "R9");
        run(1'b0, 8'h00, 5, "R9");

        // R3: first slow step lands on the 4th edge after release
        do_reset();
        run(1'b0, 8'h00, 3, "R3");
        check("R3", pattern[15:8], S_SEED);
        run(1'b0, 8'h00, 1, "R3");
        check("R3", pattern[15:8], {S_SEED[6:0], ^(S_SEED & S_TAPS)});

        // R8: fast period is 255 and never zero
        do_reset();
        for (int k = 1; k <= 255; k++) begin
            run(1'b0, 8'h00, 1, "R3");
            checks++;
            if (pattern[7:0] == 8'h00 || (k < 255 && pattern[7:0] == F_SEED)) begin
                errors++;
                $display("FAIL R8: actual=%h at step %0d expected=non-zero, not seed", pattern[7:0], k);
            end
        end
        check("R8", pattern[7:0], F_SEED);

        // R1: reset in the middle of signature mode
        run(1'b1, 8'hE7, 3, "");
        do_reset();

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule